// File: doc/BRIEF.md
# Flash Protected Range Checker

This block guards a serial flash controller against accesses that firmware has declared off limits. It holds five range registers. Each one names a span of flash in 4 KB blocks and carries two enables, one for reads and one for writes and erases. Before the controller issues a flash access, it presents the address and the direction. One cycle later the checker answers with allow or deny. On a denial it also gives the index of the lowest-numbered range that matched.

The ranges have no effect until the seal request is given. Before the seal, every access is allowed and software may rewrite the registers freely. After the seal, the protection applies and the register contents are frozen until reset. Each denial sets a sticky violation flag, which stays set until software clears it by pulsing a clear input.

The behaviour is driven by two two-state machines. The lock machine has the states LK_OPEN and LK_SEALED. It has one transition, LK_OPEN to LK_SEALED on a seal request, and reset is the only way back. The violation machine has the states ER_CLEAR and ER_HELD. It moves from ER_CLEAR to ER_HELD on a denied check. It moves from ER_HELD back to ER_CLEAR when a clear is requested in a cycle with no new denial.

Top module: `flash_range_guard`

## Requirements
- R1: After reset, every range register reads zero, `sealed` is 0, `rsp_valid` is 0 and `viol_flag` is 0.
- R2: A configuration write to index 0..4 stores the fields below, and `cfg_rd_data` returns the stored word for the index on `cfg_rd_idx` in the same cycle.
  - Bit 31 is the write/erase protect enable.
  - Bits [28:16] are the upper block number.
  - Bit 15 is the read protect enable.
  - Bits [12:0] are the lower block number.
  - Bits [30:29] and [14:13] always read 0.
  - Indices 5..7 read 0, and writes to them change nothing.
- R3: A `seal_req` pulse makes `sealed` 1 from the next cycle. It stays 1 until reset.
- R4: While sealed, configuration writes leave every register unchanged. A write in the same cycle as the seal request still takes effect.
- R5: While not sealed, every check is answered with `rsp_deny` = 0.
- R6: While sealed, a check with `chk_is_write` = 1 is denied if some range has bit 31 set and lower*4096 <= addr[24:0] <= upper*4096 + 4095. Both bounds are inclusive.
- R7: While sealed, a check with `chk_is_write` = 0 is denied on the same address test, applied to the ranges that have bit 15 set.
- R8: A range whose lower block number is greater than its upper block number matches no address.
- R9: Address bits above bit 24 do not affect the answer.
- R10: `rsp_valid` is 1 exactly in the cycle after `chk_valid`. `rsp_idx` gives the lowest-numbered matching range on a denial and is 0 on an allow.
- R11: `viol_flag` becomes 1 in the same cycle as a denial and stays 1 until `viol_clr`. If a clear and a new denial arrive together, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | 3 | Range index to write |
| cfg_wr_data | input | 32 | Range word to write |
| cfg_rd_idx | input | 3 | Range index to read back |
| cfg_rd_data | output | 32 | Stored word of the selected range |
| seal_req | input | 1 | Pulse that enables protection and freezes the registers |
| sealed | output | 1 | Protection active |
| chk_valid | input | 1 | Access check request |
| chk_addr | input | 32 | Access address |
| chk_is_write | input | 1 | 1 = write/erase, 0 = read |
| rsp_valid | output | 1 | Answer valid |
| rsp_deny | output | 1 | Access denied |
| rsp_idx | output | 3 | Lowest matching range on a denial |
| viol_flag | output | 1 | Sticky violation flag |
| viol_clr | input | 1 | Clears the violation flag |

## Verification
The hardest cases to reach from the ports all lie after the seal, because the registers can then no longer be changed.

Before sealing, the stimulus therefore programs a fixed set of ranges that covers all of these cases:
- two ranges that overlap, so that priority between them shows;
- a range whose bounds are reversed;
- a range at the very top block of the address space;
- a range with only one of its two enables set.

A configuration write is also placed in the same cycle as the seal request. After the seal, checks are placed on the exact first and last byte of each span and on the bytes just outside it. Other checks carry junk in the upper address bits. A long run of random checks and clears then follows, and a behavioural model scores every cycle.

// File: rtl/frg_pkg.sv
`timescale 1ns/1ps
package frg_pkg;

    localparam int WORD_W  = 32;
    localparam int BLK_W   = 13;
    localparam int BLK_LSB = 12;
    localparam int WPE_BIT = 31;
    localparam int RPE_BIT = 15;
    localparam int HI_LSB  = 16;
    localparam int LO_LSB  = 0;

    typedef enum logic {LK_OPEN, LK_SEALED} lock_state_e;
    typedef enum logic {ER_CLEAR, ER_HELD} err_state_e;

    typedef struct packed {
        logic             wpe;
        logic             rpe;
        logic [BLK_W-1:0] hi;
        logic [BLK_W-1:0] lo;
    } range_t;

    function automatic range_t word_to_range(input logic [WORD_W-1:0] w);
        range_t r;
        r.wpe = w[WPE_BIT];
        r.rpe = w[RPE_BIT];
        r.hi  = w[HI_LSB +: BLK_W];
        r.lo  = w[LO_LSB +: BLK_W];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] range_to_word(input range_t r);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WPE_BIT]          = r.wpe;
        w[RPE_BIT]          = r.rpe;
        w[HI_LSB +: BLK_W]  = r.hi;
        w[LO_LSB +: BLK_W]  = r.lo;
        return w;
    endfunction

endpackage

// File: rtl/frg_range_reg.sv
`timescale 1ns/1ps
module frg_range_reg
    import frg_pkg::*;
#(
    parameter int IDX   = 0,
    parameter int IDX_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                sealed_i,
    output range_t              cfg_o
);

    range_t cfg_q;
    logic   take;
    logic   unused_rsv;

    assign take       = wr_en && !sealed_i && (wr_idx == IDX_W'(IDX));
    assign unused_rsv = ^{wr_data[30:29], wr_data[14:13]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (take) begin
            cfg_q <= word_to_range(wr_data);
        end
    end

    assign cfg_o = cfg_q;

    AST_FROZEN_WHEN_SEALED: assert property (@(posedge clk) disable iff (!rst_n)
        sealed_i |=> $stable(cfg_q)); // R4

endmodule

// File: rtl/frg_range_match.sv
`timescale 1ns/1ps
module frg_range_match
    import frg_pkg::*;
(
    input  range_t              cfg_i,
    input  logic [BLK_W-1:0]    blk_i,
    input  logic                is_write_i,
    output logic                hit_o
);

    logic enabled;
    logic above_lo;
    logic below_hi;

    always_comb begin
        enabled  = is_write_i ? cfg_i.wpe : cfg_i.rpe;
        above_lo = (blk_i >= cfg_i.lo);
        below_hi = (blk_i <= cfg_i.hi);
        hit_o    = enabled && above_lo && below_hi;
    end

endmodule

// File: rtl/frg_first_hit.sv
`timescale 1ns/1ps
module frg_first_hit #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]        hits_i,
    output logic                any_o,
    output logic [IDX_W-1:0]    idx_o
);

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/flash_range_guard.sv
`timescale 1ns/1ps
module flash_range_guard
    import frg_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int ADDR_W     = 32,
    localparam int IDX_W     = $clog2(NUM_RANGES + 1),
    localparam int FLASH_AW  = BLK_LSB + BLK_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [IDX_W-1:0]    cfg_wr_idx,
    input  logic [WORD_W-1:0]   cfg_wr_data,
    input  logic [IDX_W-1:0]    cfg_rd_idx,
    output logic [WORD_W-1:0]   cfg_rd_data,
    input  logic                seal_req,
    output logic                sealed,
    input  logic                chk_valid,
    input  logic [ADDR_W-1:0]   chk_addr,
    input  logic                chk_is_write,
    output logic                rsp_valid,
    output logic                rsp_deny,
    output logic [IDX_W-1:0]    rsp_idx,
    output logic                viol_flag,
    input  logic                viol_clr
);

    lock_state_e lk_q, lk_d;
    err_state_e  er_q, er_d;

    range_t              cfgs [NUM_RANGES];
    logic [NUM_RANGES-1:0] hits;
    logic                any_hit;
    logic [IDX_W-1:0]    first_idx;
    logic [BLK_W-1:0]    blk;
    logic                deny_now;
    logic                sealed_w;
    logic                unused_addr;

    logic                rsp_valid_q;
    logic                rsp_deny_q;
    logic [IDX_W-1:0]    rsp_idx_q;

    assign blk         = chk_addr[BLK_LSB +: BLK_W];
    assign unused_addr = ^{chk_addr[ADDR_W-1:FLASH_AW], chk_addr[BLK_LSB-1:0]};

    // Range registers and comparators, one pair per range
    generate
        for (genvar g = 0; g < NUM_RANGES; g++) begin : g_range
            frg_range_reg #(.IDX(g), .IDX_W(IDX_W)) u_reg (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (cfg_wr_en),
                .wr_idx   (cfg_wr_idx),
                .wr_data  (cfg_wr_data),
                .sealed_i (sealed_w),
                .cfg_o    (cfgs[g])
            );
            frg_range_match u_match (
                .cfg_i      (cfgs[g]),
                .blk_i      (blk),
                .is_write_i (chk_is_write),
                .hit_o      (hits[g])
            );
        end
    endgenerate

    frg_first_hit #(.N(NUM_RANGES), .IDX_W(IDX_W)) u_first (
        .hits_i (hits),
        .any_o  (any_hit),
        .idx_o  (first_idx)
    );

    // Lock state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= LK_OPEN;
        else        lk_q <= lk_d;
    end

    // Lock state machine: transitions
    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_OPEN:   if (seal_req) lk_d = LK_SEALED;
            LK_SEALED: lk_d = LK_SEALED;
            default:   lk_d = LK_OPEN;
        endcase
    end

    assign sealed_w = (lk_q == LK_SEALED);
    assign deny_now = chk_valid && sealed_w && any_hit;

    // Violation state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) er_q <= ER_CLEAR;
        else        er_q <= er_d;
    end

    // Violation state machine: transitions
    always_comb begin
        er_d = er_q;
        unique case (er_q)
            ER_CLEAR: if (deny_now) er_d = ER_HELD;
            ER_HELD:  if (viol_clr && !deny_now) er_d = ER_CLEAR;
            default:  er_d = ER_CLEAR;
        endcase
    end

    // Check response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_deny_q  <= 1'b0;
            rsp_idx_q   <= '0;
        end else begin
            rsp_valid_q <= chk_valid;
            rsp_deny_q  <= deny_now;
            rsp_idx_q   <= deny_now ? first_idx : '0;
        end
    end

    // Outputs
    always_comb begin
        sealed    = sealed_w;
        viol_flag = (er_q == ER_HELD);
        rsp_valid = rsp_valid_q;
        rsp_deny  = rsp_deny_q;
        rsp_idx   = rsp_idx_q;
        cfg_rd_data = '0;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (cfg_rd_idx == IDX_W'(i)) cfg_rd_data = range_to_word(cfgs[i]);
        end
    end

    AST_SEAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> sealed); // R3
    AST_OPEN_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sealed && chk_valid) |=> !rsp_deny); // R5
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> rsp_valid); // R10
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !rsp_valid); // R10
    AST_DENY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_deny |-> (viol_flag && rsp_valid)); // R11
    AST_ALLOW_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_deny) |-> (rsp_idx == '0)); // R10

endmodule

// File: tb/sim_flash_range_guard.sv
`timescale 1ns/1ps
module sim_flash_range_guard;

    localparam int N = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_idx = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [2:0]  cfg_rd_idx = '0;
    logic [31:0] cfg_rd_data;
    logic        seal_req = 1'b0;
    logic        sealed;
    logic        chk_valid = 1'b0;
    logic [31:0] chk_addr = '0;
    logic        chk_is_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_deny;
    logic [2:0]  rsp_idx;
    logic        viol_flag;
    logic        viol_clr = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    flash_range_guard u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
        .seal_req(seal_req), .sealed(sealed),
        .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_is_write(chk_is_write),
        .rsp_valid(rsp_valid), .rsp_deny(rsp_deny), .rsp_idx(rsp_idx),
        .viol_flag(viol_flag), .viol_clr(viol_clr)
    );

    // Behavioural reference model
    logic [31:0] m_reg [N];
    bit          m_sealed;
    bit          m_rv, m_rd, m_err;
    int          m_ri;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_reg[i] = 32'h0;
            m_sealed = 0; m_rv = 0; m_rd = 0; m_ri = 0; m_err = 0;
        end else begin
            int blk, lo, hi, found;
            bit en, deny;
            blk = int'(chk_addr[24:12]);
            found = -1;
            for (int i = 0; i < N; i++) begin
                lo = int'(m_reg[i][12:0]);
                hi = int'(m_reg[i][28:16]);
                en = chk_is_write ? m_reg[i][31] : m_reg[i][15];
                if (found < 0 && en && lo <= blk && blk <= hi) found = i;
            end
            deny = chk_valid && m_sealed && (found >= 0);
            m_rv = chk_valid;
            m_rd = deny;
            m_ri = deny ? found : 0;
            m_err = deny || (m_err && !viol_clr);
            if (cfg_wr_en && !m_sealed && cfg_wr_idx < N)
                m_reg[cfg_wr_idx] = cfg_wr_data & 32'h9FFF_9FFF;
            if (seal_req) m_sealed = 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Compare every clock, 5 ns after the rising edge
    always @(posedge clk) begin
        #5;
        if (!done) begin
            logic [31:0] exp_rd;
            exp_rd = (cfg_rd_idx < N) ? m_reg[cfg_rd_idx] : 32'h0;
            check("R2 readback", cfg_rd_data, exp_rd);
            check("R3 sealed", {31'h0, sealed}, {31'h0, m_sealed});
            check("R10 rsp_valid", {31'h0, rsp_valid}, {31'h0, m_rv});
            check("R6 R7 rsp_deny", {31'h0, rsp_deny}, {31'h0, m_rd});
            if (rsp_valid) check("R10 rsp_idx", {29'h0, rsp_idx}, 32'(m_ri));
            check("R11 viol_flag", {31'h0, viol_flag}, {31'h0, m_err});
        end
    end

    task automatic idle();
        @(negedge clk);
        cfg_wr_en = 0; seal_req = 0; chk_valid = 0; viol_clr = 0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_idx = 3'(idx); cfg_wr_data = d;
        seal_req = 0; chk_valid = 0; viol_clr = 0;
    endtask

    task automatic acc(input logic [31:0] a, input bit w);
        @(negedge clk);
        cfg_wr_en = 0; seal_req = 0; viol_clr = 0;
        chk_valid = 1; chk_addr = a; chk_is_write = w;
    endtask

    task automatic sweep_rd();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cfg_wr_en = 0; seal_req = 0; chk_valid = 0; viol_clr = 0;
            cfg_rd_idx = 3'(i);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        check("R1 sealed after reset", {31'h0, sealed}, 32'h0);
        check("R1 viol_flag after reset", {31'h0, viol_flag}, 32'h0);
        check("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        rst_n = 1;
    endtask

    initial begin
        do_reset();
        sweep_rd();                       // R1: all ranges read zero
        // R2: reserved bits set in the written data must read back zero
        wr(0, 32'hE01F_6010);             // write-protect blocks 0x010..0x01F
        wr(1, 32'h0003_8000);             // read-protect blocks 0x000..0x003
        wr(2, 32'h8020_8018);             // both, blocks 0x018..0x020, overlaps range 0
        wr(3, 32'h80FF_8100);             // R8: lower > upper, empty
        wr(4, 32'h9FFF_1FFF);             // write-protect the top block only
        wr(6, 32'hFFFF_FFFF);             // R2: out-of-range index ignored
        sweep_rd();
        // R5: nothing denied before sealing
        acc(32'h0001_0000, 1); acc(32'h0000_0000, 0); acc(32'h01FF_FFFF, 1);
        idle();
        // R4: a write in the seal cycle still lands
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_idx = 3'd1; cfg_wr_data = 32'h0004_8000;
        seal_req = 1; chk_valid = 0;
        idle();
        wr(0, 32'h0000_0000);             // R4: ignored once sealed
        wr(2, 32'h0000_0000);             // R4
        sweep_rd();
        // R6: write checks at exact bounds
        acc(32'h0000_FFFF, 1); acc(32'h0001_0000, 1); acc(32'h0001_FFFF, 1);
        acc(32'h0002_0FFF, 1); acc(32'h0002_1000, 1);
        acc(32'h01FF_F000, 1); acc(32'h01FF_EFFF, 1);
        // R7: read checks
        acc(32'h0000_0000, 0); acc(32'h0000_4FFF, 0); acc(32'h0000_5000, 0);
        acc(32'h0001_8000, 0); acc(32'h01FF_F000, 0);
        // R8: empty range never matches
        acc(32'h0010_0000, 1); acc(32'h000F_F000, 0);
        // R9: upper address bits ignored
        acc(32'hFE01_0000, 1); acc(32'h8200_0000, 0); acc(32'hFE00_5000, 0);
        idle();
        // R11: clear, then clear together with a new denial
        @(negedge clk); chk_valid = 0; viol_clr = 1;
        idle();
        @(negedge clk); chk_valid = 1; chk_addr = 32'h0001_0000; chk_is_write = 1; viol_clr = 1;
        idle(); idle();
        // Random checks and clears
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            cfg_wr_en = ($urandom_range(0, 7) == 0);
            cfg_wr_idx = 3'($urandom_range(0, 7));
            cfg_wr_data = $urandom;
            chk_valid = $urandom_range(0, 1);
            chk_addr = {$urandom_range(0, 255) == 0 ? 7'h7F : 7'h00,
                        13'($urandom_range(0, 40)), 12'($urandom)};
            if ($urandom_range(0, 15) == 0) chk_addr[24:12] = 13'h1FFF;
            chk_is_write = $urandom_range(0, 1);
            viol_clr = ($urandom_range(0, 5) == 0);
            cfg_rd_idx = 3'($urandom_range(0, 7));
        end
        idle();
        // R1 R3: reset unseals and clears the ranges
        do_reset();
        sweep_rd();
        // R5 R6 after reset: unsealed again, so allowed
        wr(0, 32'h801F_0010);
        acc(32'h0001_0000, 1);
        idle(); idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule